// File: doc/BRIEF.md
# Line Voltage Sag Detector

The detector watches a stream of signed, already filtered voltage samples and decides, one line cycle at a time, whether the line has sagged. A cycle counts as sagged when every valid sample inside it has a magnitude under a programmable level. When a programmed number of such cycles occur back to back, a sticky flag is raised. An interrupt request follows the flag for as long as the interrupt enable is high.

Line-cycle boundaries come from outside as a one-clock pulse. The cycle setting is coded as one more than the number of sagged cycles wanted. The flag does not drop on a software clear alone: it also waits until the voltage has come back to or above the level. Both events must happen after the flag was set, and they may happen in either order.

Top module: `sag_det`

## Requirements
- R1: The sample magnitude is its two's-complement absolute value, and the most negative code maps to 2^(SMP_W-1) without wrapping.
- R2: A valid sample is "below" only when the level is strictly greater than its magnitude; a magnitude equal to the level is not below.
- R3: With cycle setting N, the flag rises on the clock edge that samples the cycle-end pulse completing the (N-1)-th consecutive qualifying cycle. A valid sample on the same clock as the pulse belongs to the cycle that is ending.
- R4: Cycle settings 0 and 1 behave as 2, so one qualifying cycle sets the flag.
- R5: A level setting of 0 or 1 never marks a sample below, so no sag is ever reported.
- R6: A cycle qualifies only if it holds at least one valid sample and all of its valid samples are below. A sample at or above the level clears the consecutive-cycle count on the next edge, and a cycle that is empty or fails clears it at its end.
- R7: irq_o equals sag_flag_o AND irq_en_i, combinationally, so toggling the enable takes effect without a clock edge.
- R8: Once set, the flag holds. It clears on the edge after both a clear strobe and an at-or-above sample have been seen since it was set, in either order or on the same clock. A clear strobe while the flag is low is not remembered.
- R9: The consecutive-cycle count saturates instead of wrapping. Each further qualifying cycle end at or past the target sets the flag again and discards any clear or recovery seen so far.
- R10: After reset the flag and the interrupt request are low and the cycle count is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| smp_vld_i | input | 1 | Sample strobe |
| smp_i | input | SMP_W | Filtered voltage sample, signed |
| cyc_end_i | input | 1 | One-clock pulse on the last clock of a line cycle |
| sag_lvl_i | input | LVL_W | Sag threshold level |
| sag_cyc_i | input | CYC_W | Cycle setting, one more than the cycles required |
| sag_clr_i | input | 1 | Flag clear strobe |
| irq_en_i | input | 1 | Interrupt enable |
| sag_flag_o | output | 1 | Sticky sag flag |
| irq_o | output | 1 | Interrupt request |

## Verification
The bench builds the detector with 16-bit samples and levels and a 4-bit cycle setting. The narrow cycle width puts the largest target (14 cycles) and the saturation of the count within a few hundred clocks. Full 16-bit samples let the most negative code and levels just above and at 32768 be tested directly. A behavioural model is compared on every clock. It covers directed cases for the clear and recovery orderings, re-setting while the flag is high, empty cycles, and samples that break a run, followed by a random phase that mixes levels, settings and strobes.

// File: rtl/sag_pkg.sv
package sag_pkg;
  // smallest legal cycle setting; lower codes are promoted to it
  localparam int unsigned SAG_MIN_CYC = 2;
endpackage

// File: rtl/sag_mag_cmp.sv
module sag_mag_cmp #(
  parameter int unsigned SMP_W = 16,
  parameter int unsigned LVL_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [SMP_W-1:0] smp_i,
  input  logic [LVL_W-1:0] lvl_i,
  output logic             below_o
);
  localparam int unsigned MW = (SMP_W > LVL_W) ? SMP_W : LVL_W;
  localparam logic [SMP_W-1:0] ONE_S = SMP_W'(1);
  localparam logic [LVL_W-1:0] ONE_L = LVL_W'(1);

  logic [SMP_W-1:0] mag;
  logic [MW-1:0]    mag_x, lvl_x;

  // most negative code maps to 2^(SMP_W-1) as an unsigned value
  assign mag   = smp_i[SMP_W-1] ? (~smp_i + ONE_S) : smp_i;
  assign mag_x = MW'(mag);
  assign lvl_x = MW'(lvl_i);
  assign below_o = (lvl_i > ONE_L) && (lvl_x > mag_x);

  // R5
  low_lvl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lvl_i <= ONE_L) |-> !below_o);
  // R2
  eq_lvl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lvl_x == mag_x) |-> !below_o);
endmodule

// File: rtl/sag_cyc_cnt.sv
module sag_cyc_cnt
  import sag_pkg::*;
#(
  parameter int unsigned CYC_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             smp_vld_i,
  input  logic             below_i,
  input  logic             cyc_end_i,
  input  logic [CYC_W-1:0] cyc_set_i,
  output logic             set_o,
  output logic             above_o
);
  localparam logic [CYC_W-1:0] MIN_C = CYC_W'(SAG_MIN_CYC);
  localparam logic [CYC_W-1:0] ONE_C = CYC_W'(1);
  localparam logic [CYC_W:0]   ONE_X = (CYC_W+1)'(1);

  logic [CYC_W-1:0] cnt_q, cnt_sat, n_eff, tgt;
  logic [CYC_W:0]   cnt_inc;
  logic             ok_q, has_q, ok_n, has_n, qual;

  always_comb begin
    above_o = smp_vld_i && !below_i;
    ok_n    = ok_q && !above_o;
    has_n   = has_q || smp_vld_i;
    qual    = ok_n && has_n;
    n_eff   = (cyc_set_i < MIN_C) ? MIN_C : cyc_set_i;
    tgt     = n_eff - ONE_C;
    cnt_inc = {1'b0, cnt_q} + ONE_X;
    cnt_sat = cnt_inc[CYC_W] ? cnt_q : cnt_inc[CYC_W-1:0];
    set_o   = cyc_end_i && qual && (cnt_inc >= {1'b0, tgt});
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      ok_q  <= 1'b1;
      has_q <= 1'b0;
    end else if (cyc_end_i) begin
      cnt_q <= qual ? cnt_sat : '0;
      ok_q  <= 1'b1;
      has_q <= 1'b0;
    end else begin
      if (above_o) cnt_q <= '0;
      ok_q  <= ok_n;
      has_q <= has_n;
    end
  end

  // R6
  run_break_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    above_o |=> (cnt_q == '0));
  // R6
  empty_cyc_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cyc_end_i && !has_q && !smp_vld_i) |=> (cnt_q == '0));
  // R9
  cnt_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!above_o && !cyc_end_i) |=> $stable(cnt_q));
endmodule

// File: rtl/sag_flag_ctl.sv
module sag_flag_ctl (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic above_i,
  input  logic clr_i,
  output logic flag_o
);
  logic flag_q, clr_q, rec_q, clr_any, rec_any;

  assign clr_any = clr_i || clr_q;
  assign rec_any = above_i || rec_q;
  assign flag_o  = flag_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flag_q <= 1'b0;
      clr_q  <= 1'b0;
      rec_q  <= 1'b0;
    end else if (set_i) begin
      // a fresh set restarts the release condition
      flag_q <= 1'b1;
      clr_q  <= 1'b0;
      rec_q  <= 1'b0;
    end else if (flag_q && clr_any && rec_any) begin
      flag_q <= 1'b0;
      clr_q  <= 1'b0;
      rec_q  <= 1'b0;
    end else if (flag_q) begin
      clr_q  <= clr_any;
      rec_q  <= rec_any;
    end else begin
      clr_q  <= 1'b0;
      rec_q  <= 1'b0;
    end
  end

  // R3
  flag_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(flag_q) |-> $past(set_i));
  // R8
  flag_fall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(flag_q) |-> ($past(clr_any) && $past(rec_any)));
  // R8
  flag_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_q && !clr_i && !clr_q) |=> flag_q);
endmodule

// File: rtl/sag_det.sv
module sag_det #(
  parameter int unsigned SMP_W = 16,
  parameter int unsigned LVL_W = 16,
  parameter int unsigned CYC_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             smp_vld_i,
  input  logic [SMP_W-1:0] smp_i,
  input  logic             cyc_end_i,
  input  logic [LVL_W-1:0] sag_lvl_i,
  input  logic [CYC_W-1:0] sag_cyc_i,
  input  logic             sag_clr_i,
  input  logic             irq_en_i,
  output logic             sag_flag_o,
  output logic             irq_o
);
  logic below, set_evt, above;

  sag_mag_cmp #(.SMP_W(SMP_W), .LVL_W(LVL_W)) u_cmp (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .smp_i   (smp_i),
    .lvl_i   (sag_lvl_i),
    .below_o (below)
  );

  sag_cyc_cnt #(.CYC_W(CYC_W)) u_cnt (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .smp_vld_i (smp_vld_i),
    .below_i   (below),
    .cyc_end_i (cyc_end_i),
    .cyc_set_i (sag_cyc_i),
    .set_o     (set_evt),
    .above_o   (above)
  );

  sag_flag_ctl u_flag (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .set_i   (set_evt),
    .above_i (above),
    .clr_i   (sag_clr_i),
    .flag_o  (sag_flag_o)
  );

  assign irq_o = sag_flag_o && irq_en_i;
endmodule

// File: tb/sim_sag_det.sv
module sim_sag_det;
  localparam int SW = 16;
  localparam int LW = 16;
  localparam int CW = 4;
  localparam int CMAX = (1 << CW) - 1;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          smp_vld_i = 1'b0;
  logic [SW-1:0] smp_i = '0;
  logic          cyc_end_i = 1'b0;
  logic [LW-1:0] sag_lvl_i = '0;
  logic [CW-1:0] sag_cyc_i = '0;
  logic          sag_clr_i = 1'b0;
  logic          irq_en_i = 1'b0;
  logic          sag_flag_o, irq_o;

  int nchk = 0;
  int nerr = 0;
  string cur_tag = "R10";

  always #10 clk_i = ~clk_i;

  sag_det #(.SMP_W(SW), .LVL_W(LW), .CYC_W(CW)) u0 (
    .clk_i(clk_i), .rst_ni(rst_ni), .smp_vld_i(smp_vld_i), .smp_i(smp_i),
    .cyc_end_i(cyc_end_i), .sag_lvl_i(sag_lvl_i), .sag_cyc_i(sag_cyc_i),
    .sag_clr_i(sag_clr_i), .irq_en_i(irq_en_i),
    .sag_flag_o(sag_flag_o), .irq_o(irq_o)
  );

  // behavioural reference
  int m_cnt, m_flag, m_clr, m_rec;
  bit m_ok, m_has;
  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      m_cnt = 0; m_ok = 1; m_has = 0; m_flag = 0; m_clr = 0; m_rec = 0;
    end else begin
      int s, mag, lvl, n, tgt;
      bit blw, abv, okn, hasn, qual, set;
      s = int'($signed(smp_i));
      mag = (s < 0) ? -s : s;
      lvl = int'(sag_lvl_i);
      blw = (lvl > 1) && (lvl > mag);
      abv = smp_vld_i && !blw;
      okn = m_ok && !abv;
      hasn = m_has || smp_vld_i;
      qual = okn && hasn;
      n = int'(sag_cyc_i);
      if (n < 2) n = 2;
      tgt = n - 1;
      set = cyc_end_i && qual && (m_cnt + 1 >= tgt);
      if (cyc_end_i) begin
        m_cnt = qual ? ((m_cnt + 1 > CMAX) ? CMAX : m_cnt + 1) : 0;
        m_ok = 1; m_has = 0;
      end else begin
        if (abv) m_cnt = 0;
        m_ok = okn; m_has = hasn;
      end
      if (set) begin
        m_flag = 1; m_clr = 0; m_rec = 0;
      end else if (m_flag == 1) begin
        if ((m_clr == 1 || sag_clr_i) && (m_rec == 1 || abv)) begin
          m_flag = 0; m_clr = 0; m_rec = 0;
        end else begin
          m_clr = (m_clr == 1 || sag_clr_i) ? 1 : 0;
          m_rec = (m_rec == 1 || abv) ? 1 : 0;
        end
      end else begin
        m_clr = 0; m_rec = 0;
      end
    end
  end

  task automatic chk(input bit act, input bit exp, input string tag);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s: got %0b expected %0b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic tick();
    @(negedge clk_i);
    chk(sag_flag_o, m_flag[0], {cur_tag, " flag vs model"});
    chk(irq_o, m_flag[0] && irq_en_i, {cur_tag, " irq vs model"});
  endtask

  task automatic send(input int val, input bit last);
    smp_i = val[SW-1:0];
    smp_vld_i = 1'b1;
    cyc_end_i = last;
    tick();
    smp_vld_i = 1'b0;
    cyc_end_i = 1'b0;
  endtask

  task automatic line_cyc(input int n, input int amp);
    if (n == 0) begin
      cyc_end_i = 1'b1;
      tick();
      cyc_end_i = 1'b0;
    end
    for (int i = 0; i < n; i++) send((i % 2) ? -amp : amp, i == n - 1);
  endtask

  task automatic cycles(input int k, input int amp);
    for (int i = 0; i < k; i++) line_cyc(4, amp);
  endtask

  task automatic restore();
    sag_lvl_i = LW'(100);
    sag_clr_i = 1'b1;
    send(30000, 1'b1);
    sag_clr_i = 1'b0;
    chk(sag_flag_o, 1'b0, "R8 restore clears flag");
  endtask

  task automatic finish_run();
    $display("  Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    nerr++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    // R10
    chk(sag_flag_o, 1'b0, "R10 reset flag");
    chk(irq_o, 1'b0, "R10 reset irq");
    tick();

    // R3: setting 4 -> three cycles
    cur_tag = "R3";
    sag_lvl_i = LW'(1000); sag_cyc_i = CW'(4);
    cycles(2, 500);
    chk(sag_flag_o, 1'b0, "R3 after two cycles");
    cycles(1, 500);
    chk(sag_flag_o, 1'b1, "R3 after third cycle");
    // R7
    cur_tag = "R7";
    chk(irq_o, 1'b0, "R7 irq masked");
    irq_en_i = 1'b1; #1;
    chk(irq_o, 1'b1, "R7 irq enabled");
    irq_en_i = 1'b0; #1;
    chk(irq_o, 1'b0, "R7 irq disabled");
    irq_en_i = 1'b1;
    tick();

    // R8: clear alone holds, then recovery releases
    cur_tag = "R8";
    sag_clr_i = 1'b1; tick(); sag_clr_i = 1'b0;
    chk(sag_flag_o, 1'b1, "R8 clear without recovery");
    send(1500, 1'b0);
    chk(sag_flag_o, 1'b0, "R8 clear then recovery");
    // recovery first
    restore(); sag_lvl_i = LW'(1000);
    cycles(3, 500);
    send(-1500, 1'b0);
    chk(sag_flag_o, 1'b1, "R8 recovery without clear");
    sag_clr_i = 1'b1; tick(); sag_clr_i = 1'b0;
    chk(sag_flag_o, 1'b0, "R8 recovery then clear");
    // clear while low is not remembered
    restore(); sag_lvl_i = LW'(1000);
    sag_clr_i = 1'b1; tick(); sag_clr_i = 1'b0;
    cycles(3, 500);
    send(1500, 1'b0);
    chk(sag_flag_o, 1'b1, "R8 stale clear ignored");
    sag_clr_i = 1'b1; tick(); sag_clr_i = 1'b0;
    chk(sag_flag_o, 1'b0, "R8 fresh clear");

    // R9: re-set discards a pending clear
    cur_tag = "R9";
    restore(); sag_lvl_i = LW'(1000);
    cycles(3, 500);
    sag_clr_i = 1'b1; tick(); sag_clr_i = 1'b0;
    cycles(1, 500);
    send(1500, 1'b0);
    chk(sag_flag_o, 1'b1, "R9 re-set drops pending clear");
    sag_clr_i = 1'b1; tick(); sag_clr_i = 1'b0;
    chk(sag_flag_o, 1'b0, "R9 clear after re-set");
    // largest target and saturation
    restore(); sag_lvl_i = LW'(1000); sag_cyc_i = CW'(15);
    cycles(13, 400);
    chk(sag_flag_o, 1'b0, "R9 13 of 14 cycles");
    cycles(1, 400);
    chk(sag_flag_o, 1'b1, "R9 14 cycles");
    cycles(6, 400);
    sag_clr_i = 1'b1; tick(); sag_clr_i = 1'b0;
    cycles(1, 400);
    send(1500, 1'b0);
    chk(sag_flag_o, 1'b1, "R9 saturated count still re-sets");

    // R2: equal magnitude is not below
    cur_tag = "R2";
    restore(); sag_lvl_i = LW'(500); sag_cyc_i = CW'(4);
    cycles(5, 500);
    chk(sag_flag_o, 1'b0, "R2 magnitude equals level");
    restore(); sag_lvl_i = LW'(501);
    cycles(3, 500);
    chk(sag_flag_o, 1'b1, "R2 level one above magnitude");

    // R1: most negative code
    cur_tag = "R1";
    restore(); sag_lvl_i = LW'(32768);
    for (int i = 0; i < 4; i++) for (int j = 0; j < 3; j++) send(-32768, j == 2);
    chk(sag_flag_o, 1'b0, "R1 min code magnitude 32768 at level 32768");
    restore(); sag_lvl_i = LW'(32769);
    for (int i = 0; i < 3; i++) for (int j = 0; j < 3; j++) send(-32768, j == 2);
    chk(sag_flag_o, 1'b1, "R1 min code below level 32769");

    // R5: level 0/1 never below
    cur_tag = "R5";
    for (int l = 0; l < 2; l++) begin
      restore(); sag_lvl_i = LW'(l);
      cycles(4, 0);
      chk(sag_flag_o, 1'b0, "R5 level 0 or 1 with zero samples");
    end
    restore(); sag_lvl_i = LW'(2);
    cycles(3, 0);
    chk(sag_flag_o, 1'b1, "R5 level 2 with zero samples");

    // R4: settings 0,1,2 -> one cycle; 3 -> two
    cur_tag = "R4";
    for (int c = 0; c < 3; c++) begin
      restore(); sag_lvl_i = LW'(1000); sag_cyc_i = CW'(c);
      cycles(1, 300);
      chk(sag_flag_o, 1'b1, "R4 settings 0..2 need one cycle");
    end
    restore(); sag_lvl_i = LW'(1000); sag_cyc_i = CW'(3);
    cycles(1, 300);
    chk(sag_flag_o, 1'b0, "R4 setting 3 one cycle");
    cycles(1, 300);
    chk(sag_flag_o, 1'b1, "R4 setting 3 two cycles");

    // R6: broken and empty cycles
    cur_tag = "R6";
    restore(); sag_lvl_i = LW'(1000); sag_cyc_i = CW'(4);
    cycles(1, 500);
    send(500, 0); send(-2000, 0); send(500, 0); send(-500, 1);
    cycles(2, 500);
    chk(sag_flag_o, 1'b0, "R6 mid-cycle break restarts run");
    cycles(1, 500);
    chk(sag_flag_o, 1'b1, "R6 three cycles after break");
    restore(); sag_lvl_i = LW'(1000);
    cycles(1, 500); line_cyc(0, 0); cycles(2, 500);
    chk(sag_flag_o, 1'b0, "R6 empty cycle breaks run");
    cycles(1, 500);
    chk(sag_flag_o, 1'b1, "R6 three cycles after empty one");
    restore(); sag_lvl_i = LW'(1000);
    cycles(2, 500);
    send(500, 0); send(1000, 1);
    chk(sag_flag_o, 1'b0, "R6 sample on end pulse fails the cycle");
    cycles(2, 500);
    chk(sag_flag_o, 1'b0, "R3 end-pulse sample counted in ending cycle");

    // random phase
    cur_tag = "R3/R6/R8 random";
    restore();
    for (int b = 0; b < 40; b++) begin
      sag_lvl_i = ($urandom_range(0, 4) == 0) ? LW'($urandom_range(0, 2)) : LW'($urandom_range(400, 1200));
      sag_cyc_i = CW'($urandom_range(0, 6));
      for (int k = 0; k < 100; k++) begin
        int a;
        a = ($urandom_range(0, 5) == 0) ? $urandom_range(0, 1500) : $urandom_range(0, 900);
        smp_i = ($urandom_range(0, 1) == 1) ? SW'(-a) : SW'(a);
        smp_vld_i = ($urandom_range(0, 9) < 7);
        cyc_end_i = ($urandom_range(0, 7) == 0);
        sag_clr_i = ($urandom_range(0, 19) == 0);
        irq_en_i = ($urandom_range(0, 3) != 0);
        tick();
      end
    end
    smp_vld_i = 1'b0; cyc_end_i = 1'b0; sag_clr_i = 1'b0;
    tick();
    finish_run();
  end
endmodule